// File: doc/BRIEF.md
# Serial Memory Status and Write Guard

This block holds the volatile status register of a serial-interface nonvolatile memory and rules on every write that the serial front end wants to perform. The front end decodes the serial commands and hands this block single-cycle pulses. One pulse sets the write-enable latch and another clears it. A status-write pulse carries its data byte. A command-end pulse fires when chip select rises after a completed array write or status write. The block returns the status byte that a status read shifts out. For any array address it also answers combinationally whether a byte may be written there. The front end applies that answer to every auto-incremented byte of a burst.

Protection has two layers. Two block-protect bits select a fixed upper fraction of the array: none, the top quarter, the top half or all of it. A status-write-disable bit, combined with the active-low write-protect pin, freezes the register itself. All state resets to zero and keeps nothing across power cycles. All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake or back-pressure applies.

Top module: `spi_mem_guard`

## Requirements
- R1: The status byte `status_o` has bit 7 = status-write-disable (SWD), bit 3 = BP1, bit 2 = BP0, bit 1 = write-enable latch (WEL). Bits 6, 5, 4 and 0 always read 0.
- R2: After reset, `status_o` is 8'h00 and `write_ok_o` is 0 for every address.
- R3: A `wren_i` pulse sets WEL and a `wrdi_i` pulse clears it, visible in `status_o` the cycle after the pulse. When a clear and a set arrive in the same cycle, the clear wins.
- R4: A `cmd_end_i` pulse clears WEL on the following cycle. It also wins over a simultaneous `wren_i`.
- R5: A `wrsr_i` pulse with WEL set and no hardware lock loads bits 7, 3 and 2 of `wrsr_data_i` into SWD, BP1 and BP0 on the next cycle. The other data bits are ignored. Without WEL, the pulse changes nothing.
- R6: While SWD = 1 and `wp_n_i` = 0 (hardware lock), a `wrsr_i` pulse changes no status bit, even with WEL set. With SWD = 0 or `wp_n_i` = 1, the status write works whenever WEL is set.
- R7: `prot_o` is a combinational function of BP1:BP0 and the 15-bit `addr_i`. 00 protects nothing, 01 protects 0x6000–0x7FFF, 10 protects 0x4000–0x7FFF, and 11 protects 0x0000–0x7FFF.
- R8: `write_ok_o` is 1 exactly when WEL is set and `prot_o` is 0, in the same cycle as the address. The hardware lock does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wren_i | input | 1 | Write-enable command pulse |
| wrdi_i | input | 1 | Write-disable command pulse |
| wrsr_i | input | 1 | Status-write command pulse |
| wrsr_data_i | input | 8 | Data byte of the status write |
| cmd_end_i | input | 1 | Chip select rose after a completed write command |
| addr_i | input | 15 | Array address to rule on |
| status_o | output | 8 | Status byte for status reads |
| prot_o | output | 1 | Address lies in a protected block |
| write_ok_o | output | 1 | Byte write at address is allowed |

## Verification
Register effects of the pulses (R3–R6) appear in `status_o` exactly one clock after the edge that samples the pulse. The address answers (R7, R8) are combinational and valid in the same cycle as the address and the current state. The bench drives all inputs on the falling edge and checks the combinational answers a nanosecond later, against a model state that has not yet moved. It then advances its model at the rising edge, so the next falling-edge sample compares the status byte one cycle after the pulse.

// File: rtl/spi_mem_guard_pkg.sv
package spi_mem_guard_pkg;
  localparam int STAT_W   = 8;
  localparam int SWD_POS  = 7;
  localparam int BP1_POS  = 3;
  localparam int BP0_POS  = 2;
  localparam int WEL_POS  = 1;
  localparam logic [STAT_W-1:0] WR_MASK =
    (STAT_W'(1) << SWD_POS) | (STAT_W'(1) << BP1_POS) | (STAT_W'(1) << BP0_POS);

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;
endpackage

// File: rtl/guard_wel.sv
module guard_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_q <= 1'b0;
    else if (clr_i) wel_q <= 1'b0;
    else if (set_i) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wel_o);
  a_r3_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> wel_o);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(wel_o));
endmodule

// File: rtl/guard_statreg.sv
module guard_statreg
  import spi_mem_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_i,
  input  logic              wp_n_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              hw_lock_o
);
  logic [STAT_W-1:0] stat_q;
  logic              lock;
  logic              take;

  assign lock = stat_q[SWD_POS] & ~wp_n_i;
  assign take = wr_i & wel_i & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= '0;
    else if (take) stat_q <= data_i & WR_MASK;
  end

  assign stat_o    = stat_q;
  assign hw_lock_o = lock;

  a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[SWD_POS] && !wp_n_i) |=> $stable(stat_o));
  a_r5_no_wel_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_i |=> $stable(stat_o));
  a_r5_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wel_i && !stat_q[SWD_POS]) |=> (stat_o == ($past(data_i) & WR_MASK)));
endmodule

// File: rtl/guard_bp_decode.sv
module guard_bp_decode
  import spi_mem_guard_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic [1:0]    bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          prot_o
);
  localparam logic [AW-1:0] QUARTER_BASE = AW'(3) << (AW - 2);
  localparam logic [AW-1:0] HALF_BASE    = AW'(1) << (AW - 1);

  always_comb begin
    unique case (bp_e'(bp_i))
      BP_NONE:    prot_o = 1'b0;
      BP_QUARTER: prot_o = (addr_i >= QUARTER_BASE);
      BP_HALF:    prot_o = (addr_i >= HALF_BASE);
      default:    prot_o = 1'b1;
    endcase
  end

  always_comb begin
    if (bp_i == 2'b00) a_r7_none_open: assert (!prot_o);
    if (bp_i == 2'b11) a_r7_all_shut: assert (prot_o);
  end
endmodule

// File: rtl/spi_mem_guard.sv
module spi_mem_guard
  import spi_mem_guard_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n_i,
  input  logic          wren_i,
  input  logic          wrdi_i,
  input  logic          wrsr_i,
  input  logic [7:0]    wrsr_data_i,
  input  logic          cmd_end_i,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    status_o,
  output logic          prot_o,
  output logic          write_ok_o
);
  logic              wel;
  logic [STAT_W-1:0] stat;
  logic              hw_lock;

  guard_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wren_i),
    .clr_i (wrdi_i | cmd_end_i),
    .wel_o (wel)
  );

  guard_statreg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wel_i     (wel),
    .wp_n_i    (wp_n_i),
    .wr_i      (wrsr_i),
    .data_i    (wrsr_data_i),
    .stat_o    (stat),
    .hw_lock_o (hw_lock)
  );

  guard_bp_decode #(.AW(AW)) u_dec (
    .bp_i   (stat[BP1_POS:BP0_POS]),
    .addr_i (addr_i),
    .prot_o (prot_o)
  );

  assign status_o   = stat | (STAT_W'(wel) << WEL_POS);
  assign write_ok_o = wel & ~prot_o;

  a_r1_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6:4] == 3'b000) && !status_o[0]);
  a_r8_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    write_ok_o |-> status_o[WEL_POS]);
  a_r8_lock_independent: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |-> (write_ok_o == (status_o[WEL_POS] && !prot_o)));
  a_r4_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end_i |=> !status_o[WEL_POS]);
endmodule

// File: tb/spi_mem_guard_tb_top.sv
module spi_mem_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n_i = 1'b1;
  logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, cmd_end_i = 1'b0;
  logic [7:0]  wrsr_data_i = '0;
  logic [14:0] addr_i = '0;
  logic [7:0]  status_o;
  logic        prot_o, write_ok_o;

  int vectors = 0;
  int fails = 0;
  bit m_wel, m_swd;
  bit [1:0] m_bp;

  always #2 clk = ~clk;

  spi_mem_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .cmd_end_i(cmd_end_i),
    .addr_i(addr_i), .status_o(status_o), .prot_o(prot_o), .write_ok_o(write_ok_o)
  );

  function automatic bit f_prot(bit [1:0] bp, bit [14:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a >= 15'h6000;
      2'b10: return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] f_status();
    return {m_swd, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_now(string tag);
    #1;
    check({tag, " R1/R3/R5 status"}, 32'(status_o), 32'(f_status()));
    check("R7 prot", 32'(prot_o), 32'(f_prot(m_bp, addr_i)));
    check("R8 write_ok", 32'(write_ok_o), 32'(m_wel && !f_prot(m_bp, addr_i)));
  endtask

  task automatic model_edge();
    bit lock;
    lock = m_swd && !wp_n_i;
    if (wrsr_i && m_wel && !lock) begin
      m_swd = wrsr_data_i[7];
      m_bp  = wrsr_data_i[3:2];
    end
    if (wrdi_i || cmd_end_i) m_wel = 1'b0;
    else if (wren_i) m_wel = 1'b1;
  endtask

  task automatic step(bit wen, bit wdi, bit wsr, bit [7:0] d, bit ce, bit wp, bit [14:0] a, string tag);
    @(negedge clk);
    wren_i = wen; wrdi_i = wdi; wrsr_i = wsr; wrsr_data_i = d;
    cmd_end_i = ce; wp_n_i = wp; addr_i = a;
    check_now(tag);
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset status", 32'(status_o), 32'h0);
    check("R2 reset write_ok", 32'(write_ok_o), 32'h0);
    rst_n = 1'b1;

    // R3: set then simultaneous set+clear
    step(1,0,0,8'h00,0,1,15'h7FFF,"R3 idle");
    step(1,1,0,8'h00,0,1,15'h0000,"R3 set");
    step(0,0,0,8'h00,0,1,15'h0000,"R3 clear wins");
    // R4: end pulse beats wren
    step(1,0,0,8'h00,0,1,15'h0000,"R4 pre");
    step(1,0,0,8'h00,1,1,15'h1234,"R4 end");
    step(0,0,0,8'h00,0,1,15'h1234,"R4 after");
    // R5: WRSR without WEL ignored, then with WEL, junk bits dropped
    step(0,0,1,8'hFF,0,1,15'h0,"R5 no wel");
    step(1,0,0,8'h00,0,1,15'h0,"R5 wren");
    step(0,0,1,8'h77,0,1,15'h5FFF,"R5 write");
    step(0,0,0,8'h00,0,1,15'h5FFF,"R7 quarter edge low");
    step(0,0,0,8'h00,0,1,15'h6000,"R7 quarter edge high");
    // R6: set SWD, lock with pin low
    step(0,0,1,8'h88,0,1,15'h3FFF,"R6 set swd");
    step(0,0,1,8'h00,0,0,15'h4000,"R6 locked");
    step(0,0,0,8'h00,0,0,15'h4000,"R6 still locked");
    step(0,0,1,8'h00,0,1,15'h4000,"R6 pin high unlocks");
    step(0,0,0,8'h00,0,1,15'h0000,"R6 after");

    for (int i = 0; i < 4000; i++) begin
      bit [7:0] r;
      r = 8'($urandom);
      step(r[0] & r[1], r[2] & r[3] & r[4], r[5] | r[6],
           8'($urandom), r[7] & r[4] & r[2], 1'($urandom % 3 != 0),
           15'($urandom), "R3 R4 R5 R6 random");
    end
    @(negedge clk);
    check_now("R8 final");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule